// File: doc/BRIEF.md
# Serial Register Control Port

This block is a slave port driven by an external controller over a three-wire serial link: a control clock, a serial data input and an active-low select. It writes and reads a small bank of 8-bit configuration registers and holds a power-down flag. The serial output comes with an enable for a shared tri-state pad. Every transfer opens with an instruction byte. That byte sets the power state and names a register, a direction and a length. For two-byte instructions a second byte follows: the controller writes it into the register, or the port shifts the register's contents out during it.

The block runs on a fast system clock. It samples the three link wires through a synchronizer and finds control-clock edges from the sampled level. Each byte is eight control-clock pulses, most significant bit first. Input bits are taken on falling edges and output bits are launched on rising edges. If the select is released before a byte is complete, the transfer is dropped: the bit and byte counts start over and no register changes. The select may stay low across many instructions in a row. A two-byte instruction may also be split across two select periods.

Top module: `serctl_port`

## Requirements
- R1: After reset every register reads 0x00, `power_down` is 1 and `sdo_en` is 0.
- R2: The instruction byte has this layout: bit 7 is the power bit (0 = up, 1 = down), bits 6..3 are the register address, bit 2 is the direction (1 = read, 0 = write), bit 1 is the length (1 = two bytes, 0 = one byte), and bit 0 is ignored. Bits are taken MSB first on falling `sck` edges. `power_down` takes bit 7 once the eighth bit of the instruction byte is in.
- R3: A one-byte instruction (bit 1 = 0) changes only `power_down`. No register changes, whatever the other bits hold.
- R4: In a two-byte write, the second byte is loaded into the addressed register after the eighth falling edge of that byte.
- R5: In a two-byte read, the addressed register is driven on `sdo` MSB first, one bit per rising `sck` edge, across the eight pulses of the second byte. The register keeps its value.
- R6: `sdo_en` is 0 whenever the port is deselected. It is 1 only during the second byte of a read.
- R7: Releasing the select before the eighth pulse of either byte discards the transfer and leaves every register unchanged. The next selected pulse is bit 7 of a fresh instruction byte.
- R8: A two-byte instruction whose second byte comes in a separate select period behaves the same as a contiguous one.
- R9: With the select held low, instructions run back to back with no gap.
- R10: Writes to unmapped addresses (3, 11 to 15) are discarded. Reads from them return 0x00.
- R11: Register addresses: 0 control, 1 latch data, 2 latch direction, 4 receive gain, 5 transmit gain, 6/7/8 balance filter 1/2/3, 9 receive slot, 10 transmit slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial control clock (idles low) |
| sel_n | input | 1 | Active-low port select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for the tri-state pad |
| power_down | output | 1 | Power state, 1 = powered down |
| cfg_ctrl | output | 8 | Register 0: control |
| cfg_latch | output | 8 | Register 1: latch data |
| cfg_ldir | output | 8 | Register 2: latch direction |
| cfg_rx_gain | output | 8 | Register 4: receive gain |
| cfg_tx_gain | output | 8 | Register 5: transmit gain |
| cfg_bal1 | output | 8 | Register 6: balance filter 1 |
| cfg_bal2 | output | 8 | Register 7: balance filter 2 |
| cfg_bal3 | output | 8 | Register 8: balance filter 3 |
| cfg_rx_slot | output | 8 | Register 9: receive slot |
| cfg_tx_slot | output | 8 | Register 10: transmit slot |

## Verification
The bench builds the port with `SYNC_STAGES` = 3, one stage more than the default, and runs the link with a half period of six system clocks. This leaves the longest synchronizer and edge-detect path only just inside one half period. Any read bit that comes out late shows up as a wrong sampled bit. The longer chain also widens the window between a select release and the end of a partial byte, which exercises aborts in both the first and the second byte.

// File: rtl/serctl_pkg.sv
package serctl_pkg;

    localparam int REG_W     = 8;
    localparam int ADDR_W    = 4;
    localparam int NUM_SLOTS = 1 << ADDR_W;
    localparam int CNT_W     = $clog2(REG_W);

    // instruction byte field positions
    localparam int BIT_PWR  = 7;
    localparam int ADDR_HI  = 6;
    localparam int ADDR_LO  = 3;
    localparam int BIT_RD   = 2;
    localparam int BIT_LONG = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL    = 4'd0,
        A_LATCH   = 4'd1,
        A_LDIR    = 4'd2,
        A_RXGAIN  = 4'd4,
        A_TXGAIN  = 4'd5,
        A_BAL1    = 4'd6,
        A_BAL2    = 4'd7,
        A_BAL3    = 4'd8,
        A_RXSLOT  = 4'd9,
        A_TXSLOT  = 4'd10
    } reg_addr_e;

    function automatic logic addr_mapped(input int a);
        case (a)
            A_CTRL, A_LATCH, A_LDIR, A_RXGAIN, A_TXGAIN,
            A_BAL1, A_BAL2, A_BAL3, A_RXSLOT, A_TXSLOT: return 1'b1;
            default:                                   return 1'b0;
        endcase
    endfunction

    typedef struct packed {
        logic              sck_q;
        logic [CNT_W-1:0]  bit_cnt;
        logic              second;
        logic              rd_phase;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  rx_sh;
        logic [REG_W-1:0]  tx_sh;
        logic              dout;
        logic              pwr_dn;
    } eng_state_t;

endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] lvl_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    chain_q[s] <= async_i;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign lvl_o = chain_q[STAGES-1];

endmodule

// File: rtl/serctl_regbank.sv
module serctl_regbank
    import serctl_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [REG_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [REG_W-1:0]           rd_data,
    output logic [NUM_SLOTS*REG_W-1:0] regs_o
);

    genvar a;
    generate
        for (a = 0; a < NUM_SLOTS; a++) begin : g_slot
            if (addr_mapped(a)) begin : g_store
                logic [REG_W-1:0] val_d, val_q;

                always_comb begin
                    val_d = val_q;
                    if (wr_en && (wr_addr == ADDR_W'(a))) begin
                        val_d = wr_data;
                    end
                end

                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) val_q <= '0;
                    else        val_q <= val_d;
                end

                assign regs_o[a*REG_W +: REG_W] = val_q;
            end else begin : g_hole
                assign regs_o[a*REG_W +: REG_W] = '0;
            end
        end
    endgenerate

    assign rd_data = regs_o[{rd_addr, 3'b000} +: REG_W];

endmodule

// File: rtl/serctl_engine.sv
module serctl_engine
    import serctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sck,
    input  logic              din,
    input  logic [REG_W-1:0]  rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [REG_W-1:0]  wr_data,
    output logic              dout,
    output logic              dout_en,
    output logic              pwr_dn,
    output logic              sck_fall
);

    localparam eng_state_t ST_RST = '{pwr_dn: 1'b1, default: '0};
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(REG_W - 1);

    eng_state_t st_d, st_q;
    logic [REG_W-1:0] shifted;
    logic sck_rise;

    always_comb begin
        st_d     = st_q;
        wr_en    = 1'b0;
        shifted  = {st_q.rx_sh[REG_W-2:0], din};
        sck_rise = sck && !st_q.sck_q;
        sck_fall = !sck && st_q.sck_q;

        st_d.sck_q = sck;

        if (!sel) begin
            // mid-byte release: drop the whole instruction
            if (st_q.bit_cnt != '0) begin
                st_d.second   = 1'b0;
                st_d.rd_phase = 1'b0;
            end
            st_d.bit_cnt = '0;
        end else begin
            if (sck_rise && st_q.rd_phase) begin
                st_d.dout  = st_q.tx_sh[REG_W-1];
                st_d.tx_sh = {st_q.tx_sh[REG_W-2:0], 1'b0};
            end
            if (sck_fall) begin
                st_d.rx_sh   = shifted;
                st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                if (st_q.bit_cnt == LAST_BIT) begin
                    if (!st_q.second) begin
                        st_d.pwr_dn = shifted[BIT_PWR];
                        if (shifted[BIT_LONG]) begin
                            st_d.second   = 1'b1;
                            st_d.addr     = shifted[ADDR_HI:ADDR_LO];
                            st_d.rd_phase = shifted[BIT_RD];
                            st_d.tx_sh    = rd_data;
                            st_d.dout     = 1'b0;
                        end
                    end else begin
                        st_d.second   = 1'b0;
                        st_d.rd_phase = 1'b0;
                        wr_en         = !st_q.rd_phase;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign rd_addr = shifted[ADDR_HI:ADDR_LO];
    assign wr_addr = st_q.addr;
    assign wr_data = shifted;
    assign dout    = st_q.dout;
    assign dout_en = st_q.rd_phase && sel;
    assign pwr_dn  = st_q.pwr_dn;

endmodule

// File: rtl/serctl_port.sv
module serctl_port
    import serctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             sel_n,
    input  logic             sdi,
    output logic             sdo,
    output logic             sdo_en,
    output logic             power_down,
    output logic [REG_W-1:0] cfg_ctrl,
    output logic [REG_W-1:0] cfg_latch,
    output logic [REG_W-1:0] cfg_ldir,
    output logic [REG_W-1:0] cfg_rx_gain,
    output logic [REG_W-1:0] cfg_tx_gain,
    output logic [REG_W-1:0] cfg_bal1,
    output logic [REG_W-1:0] cfg_bal2,
    output logic [REG_W-1:0] cfg_bal3,
    output logic [REG_W-1:0] cfg_rx_slot,
    output logic [REG_W-1:0] cfg_tx_slot
);

    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0]          pins_lvl;
    logic                       sel_w;
    logic                       sck_fall_w;
    logic                       wr_en_w;
    logic [ADDR_W-1:0]          wr_addr_w;
    logic [REG_W-1:0]           wr_data_w;
    logic [ADDR_W-1:0]          rd_addr_w;
    logic [REG_W-1:0]           rd_data_w;
    logic [NUM_SLOTS*REG_W-1:0] regs_w;

    serctl_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdi, sel_n, sck}),
        .lvl_o   (pins_lvl)
    );

    assign sel_w = !pins_lvl[1];

    serctl_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel_w),
        .sck      (pins_lvl[0]),
        .din      (pins_lvl[2]),
        .rd_data  (rd_data_w),
        .rd_addr  (rd_addr_w),
        .wr_en    (wr_en_w),
        .wr_addr  (wr_addr_w),
        .wr_data  (wr_data_w),
        .dout     (sdo),
        .dout_en  (sdo_en),
        .pwr_dn   (power_down),
        .sck_fall (sck_fall_w)
    );

    serctl_regbank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_w),
        .wr_addr (wr_addr_w),
        .wr_data (wr_data_w),
        .rd_addr (rd_addr_w),
        .rd_data (rd_data_w),
        .regs_o  (regs_w)
    );

    assign cfg_ctrl    = regs_w[A_CTRL   *REG_W +: REG_W];
    assign cfg_latch   = regs_w[A_LATCH  *REG_W +: REG_W];
    assign cfg_ldir    = regs_w[A_LDIR   *REG_W +: REG_W];
    assign cfg_rx_gain = regs_w[A_RXGAIN *REG_W +: REG_W];
    assign cfg_tx_gain = regs_w[A_TXGAIN *REG_W +: REG_W];
    assign cfg_bal1    = regs_w[A_BAL1   *REG_W +: REG_W];
    assign cfg_bal2    = regs_w[A_BAL2   *REG_W +: REG_W];
    assign cfg_bal3    = regs_w[A_BAL3   *REG_W +: REG_W];
    assign cfg_rx_slot = regs_w[A_RXSLOT *REG_W +: REG_W];
    assign cfg_tx_slot = regs_w[A_TXSLOT *REG_W +: REG_W];

endmodule

// File: rtl/serctl_port_chk.sv
module serctl_port_chk
    import serctl_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       sel,
    input logic                       sck_fall,
    input logic                       wr_en,
    input logic                       dout_en,
    input logic                       pwr_dn,
    input logic [ADDR_W-1:0]          rd_addr,
    input logic [REG_W-1:0]           rd_data,
    input logic [NUM_SLOTS*REG_W-1:0] regs
);

    assert_oe_off_deselected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> !dout_en);

    assert_no_write_deselected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> !wr_en);

    assert_write_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sck_fall);

    assert_regs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));

    assert_hole_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_mapped(int'(rd_addr)) |-> rd_data == '0);

    assert_pwr_at_byte_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwr_dn) |-> $past(sck_fall));

endmodule

bind serctl_port serctl_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel_w),
    .sck_fall (sck_fall_w),
    .wr_en    (wr_en_w),
    .dout_en  (sdo_en),
    .pwr_dn   (power_down),
    .rd_addr  (rd_addr_w),
    .rd_data  (rd_data_w),
    .regs     (regs_w)
);

// File: tb/serctl_port_bench.sv
module serctl_port_bench;

    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic sel_n = 1'b1;
    logic sdi = 1'b0;
    logic sdo, sdo_en, power_down;
    logic [7:0] cfg_ctrl, cfg_latch, cfg_ldir, cfg_rx_gain, cfg_tx_gain;
    logic [7:0] cfg_bal1, cfg_bal2, cfg_bal3, cfg_rx_slot, cfg_tx_slot;

    int errors = 0;
    int checks = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    logic [7:0] exp_reg [16];
    logic       exp_pwr;

    always #10 clk = ~clk;

    serctl_port #(.SYNC_STAGES(3)) u_serctl_port (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sel_n(sel_n), .sdi(sdi),
        .sdo(sdo), .sdo_en(sdo_en), .power_down(power_down),
        .cfg_ctrl(cfg_ctrl), .cfg_latch(cfg_latch), .cfg_ldir(cfg_ldir),
        .cfg_rx_gain(cfg_rx_gain), .cfg_tx_gain(cfg_tx_gain),
        .cfg_bal1(cfg_bal1), .cfg_bal2(cfg_bal2), .cfg_bal3(cfg_bal3),
        .cfg_rx_slot(cfg_rx_slot), .cfg_tx_slot(cfg_tx_slot)
    );

    function automatic bit is_mapped(int a);
        return (a <= 2) || (a >= 4 && a <= 10);
    endfunction

    function automatic logic [7:0] port_val(int a);
        case (a)
            0: return cfg_ctrl;
            1: return cfg_latch;
            2: return cfg_ldir;
            4: return cfg_rx_gain;
            5: return cfg_tx_gain;
            6: return cfg_bal1;
            7: return cfg_bal2;
            8: return cfg_bal3;
            9: return cfg_rx_slot;
            10: return cfg_tx_slot;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] instr(bit pwr, int a, bit rd, bit two);
        return {pwr, 4'(a), rd, two, 1'b0};
    endfunction

    task automatic check(string req, string what, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // idle comparison against the reference state, every clock
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            for (int a = 0; a < 16; a++) begin
                if (is_mapped(a)) check(cur_req, $sformatf("reg %0d", a), port_val(a), exp_reg[a]);
            end
            check(cur_req, "power_down", {7'd0, power_down}, {7'd0, exp_pwr});
            check("R6", "sdo_en idle", {7'd0, sdo_en}, 8'h00);
        end
    end

    task automatic sel_on();
        cmp_en = 1'b0;
        sel_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic sel_off(bit compare);
        sel_n = 1'b1;
        repeat (2*HALF) @(negedge clk);
        cmp_en = compare;
    endtask

    // nbits pulses MSB first; sdo sampled at the end of each high half
    task automatic xfer(input logic [7:0] tx, input int nbits,
                        output logic [7:0] rx, output bit oe_all, output bit oe_any);
        rx = 8'h00; oe_all = 1'b1; oe_any = 1'b0;
        for (int i = 7; i > 7 - nbits; i--) begin
            sdi = tx[i];
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            rx[i] = sdo;
            oe_all &= sdo_en;
            oe_any |= sdo_en;
            sck = 1'b0;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic byte_out(input logic [7:0] tx);
        logic [7:0] r; bit a, b;
        xfer(tx, 8, r, a, b);
    endtask

    task automatic do_write(bit pwr, int a, logic [7:0] d);
        sel_on();
        byte_out(instr(pwr, a, 1'b0, 1'b1));
        byte_out(d);
        exp_pwr = pwr;
        if (is_mapped(a)) exp_reg[a] = d;
        sel_off(1'b1);
    endtask

    task automatic do_read(string req, bit pwr, int a);
        logic [7:0] r; bit all, any;
        sel_on();
        xfer(instr(pwr, a, 1'b1, 1'b1), 8, r, all, any);
        check("R6", "sdo_en during instruction byte", {7'd0, any}, 8'h00);
        xfer(8'h00, 8, r, all, any);
        exp_pwr = pwr;
        check(req, $sformatf("read addr %0d", a), r, is_mapped(a) ? exp_reg[a] : 8'h00);
        check("R6", "sdo_en during read byte", {7'd0, all}, 8'h01);
        sel_off(1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] r; bit all, any;
        for (int a = 0; a < 16; a++) exp_reg[a] = 8'h00;
        exp_pwr = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1", "sdo_en reset", {7'd0, sdo_en}, 8'h00);
        cur_req = "R1";
        cmp_en = 1'b1;
        repeat (4) @(negedge clk);

        // R4 R11 R2: write every mapped address, distinct MSB/LSB patterns
        cur_req = "R4";
        for (int a = 0; a < 16; a++) begin
            if (is_mapped(a)) do_write(1'b0, a, 8'h81 ^ 8'(a * 8'h13));
        end
        // R5 R11: read each back
        for (int a = 0; a < 16; a++) begin
            if (is_mapped(a)) do_read("R5", 1'b0, a);
        end

        // R3: single-byte instructions touch only power
        cur_req = "R3";
        sel_on(); byte_out(instr(1'b1, 1, 1'b0, 1'b0)); exp_pwr = 1'b1; sel_off(1'b1);
        check("R3", "power after single byte", {7'd0, power_down}, 8'h01);
        sel_on(); byte_out(instr(1'b0, 5, 1'b1, 1'b0) | 8'h01); exp_pwr = 1'b0; sel_off(1'b1);
        check("R2", "power up from bit 7", {7'd0, power_down}, 8'h00);

        // R10: unmapped addresses
        cur_req = "R10";
        do_write(1'b0, 3, 8'hA5);
        do_write(1'b0, 11, 8'h5A);
        do_write(1'b0, 15, 8'hFF);
        do_read("R10", 1'b0, 3);
        do_read("R10", 1'b0, 15);

        // R7: abort in the instruction byte, then in a write's data byte
        cur_req = "R7";
        sel_on(); xfer(instr(1'b1, 0, 1'b0, 1'b1), 5, r, all, any); sel_off(1'b1);
        sel_on(); byte_out(instr(1'b0, 4, 1'b0, 1'b1));
        xfer(8'h3C, 4, r, all, any);
        exp_pwr = 1'b0;
        sel_off(1'b1);
        // abort in a read's data byte releases sdo_en
        sel_on(); byte_out(instr(1'b0, 6, 1'b1, 1'b1));
        xfer(8'h00, 3, r, all, any);
        sel_off(1'b1);
        check("R7", "sdo_en after read abort", {7'd0, sdo_en}, 8'h00);
        // fresh instruction after an abort
        do_write(1'b0, 4, 8'hC3);
        do_read("R7", 1'b0, 4);

        // R8: second byte in its own select period
        cur_req = "R8";
        sel_on(); byte_out(instr(1'b0, 9, 1'b0, 1'b1)); sel_off(1'b0);
        check("R6", "sdo_en between split bytes", {7'd0, sdo_en}, 8'h00);
        sel_on(); byte_out(8'h6E); exp_reg[9] = 8'h6E; exp_pwr = 1'b0; sel_off(1'b1);
        sel_on(); byte_out(instr(1'b0, 9, 1'b1, 1'b1)); sel_off(1'b0);
        check("R6", "sdo_en deselected mid read", {7'd0, sdo_en}, 8'h00);
        sel_on(); xfer(8'h00, 8, r, all, any); sel_off(1'b1);
        check("R8", "split read", r, 8'h6E);

        // R9: select held low across several instructions
        cur_req = "R9";
        sel_on();
        byte_out(instr(1'b0, 7, 1'b0, 1'b1)); byte_out(8'h01);
        byte_out(instr(1'b0, 8, 1'b0, 1'b1)); byte_out(8'h80);
        byte_out(instr(1'b1, 0, 1'b0, 1'b0));
        xfer(instr(1'b0, 8, 1'b1, 1'b1), 8, r, all, any);
        xfer(8'h00, 8, r, all, any);
        check("R9", "back-to-back read", r, 8'h80);
        byte_out(instr(1'b1, 2, 1'b0, 1'b1)); byte_out(8'hE7);
        exp_reg[7] = 8'h01; exp_reg[8] = 8'h80; exp_reg[2] = 8'hE7; exp_pwr = 1'b1;
        sel_off(1'b1);
        check("R9", "back-to-back write", cfg_ldir, 8'hE7);
        check("R9", "power from last instruction", {7'd0, power_down}, 8'h01);

        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule